// File: doc/BRIEF.md
# Line-Rate Dual-Tone Audio Generator

This block makes a 1-bit square-wave audio signal whose pitch follows a single logic level. It has no audio divider of its own. Instead it takes the horizontal pixel position from an existing video timing chain and advances its tone counter once per scanline, on the cycle where that position is zero. With a 525-line, 60 Hz raster, the counter therefore steps at about 31.5 kHz.

Each time the counter is stepped, it is first compared with a limit. A high level selects a limit of 180 and a low level selects 300. If the counter is already past the limit, the audio output inverts and the counter goes back to zero. Otherwise the counter goes up by one. Each half period is therefore the limit plus two scanlines, which gives a tone near 87 Hz for a high level and near 52 Hz for a low level.

A change of level does not clear the counter. It takes effect at the next comparison. The output is meant to drive one bidirectional pad, set as an output, that feeds an external filter and speaker.

Top module: `line_tone_audio`

## Requirements
- R1: While reset is low at a clock edge, the audio output is driven to 0 and the tone counter is cleared.
- R2: The tone counter and the audio output change only on clock edges where the horizontal position is 0. At any other position, both hold their values for any number of cycles.
- R3: On a line event, if the counter is strictly greater than the active limit, the audio output inverts and the counter returns to 0. Otherwise the counter increments by 1. A half period is therefore the limit plus 2 line events.
- R4: When the level input is 1, the limit is 180, so the audio output inverts every 182 line events.
- R5: When the level input is 0, the limit is 300, so the audio output inverts every 302 line events.
- R6: Changing the level does not clear the counter. At the next line event, the counter is compared against the newly selected limit. For example, a counter at 200 under a low level toggles on the first line event after the level goes high.
- R7: The tone counter never exceeds the larger limit plus 1, so it fits in 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| hpos_i | input | 10 | Horizontal pixel position from the video timing chain |
| level_i | input | 1 | Logic level being shown; selects the tone |
| audio_o | output | 1 | Square-wave audio output |

## Verification
The assertions assume that the horizontal position is a well-defined value on every clock after reset. They do not assume that position 0 lasts only one cycle or that it repeats at a fixed spacing. The properties relate each line event to the counter and the output, whatever the gap between events.

The bench uses short synthetic scanlines, with the position stepping 0, 1, 2, so that hundreds of line events fit in a short run. It changes the level and reset only away from the clock edge. It also holds the position off zero for long stretches to show that nothing advances.

// File: rtl/line_tone_pkg.sv
// Package: shared constants and types for the line-rate tone generator.
// Assumes a 10-bit horizontal position and a counter wide enough for the
// larger of the two limits plus one.
package line_tone_pkg;
    localparam int HPOS_W   = 10;
    localparam int CNT_W    = 9;
    localparam int LIMIT_HI = 180;
    localparam int LIMIT_LO = 300;
endpackage

// File: rtl/tone_line_tick.sv
// Module: tone_line_tick
// Raises a one-cycle step request whenever the horizontal position equals
// the parameterised trigger column. Assumes the position input comes from
// a registered timing counter, so no glitch filtering is needed here.
module tone_line_tick #(
    parameter int HPOS_W   = 10,
    parameter int TRIG_COL = 0
) (
    input  logic [HPOS_W-1:0] hpos,
    output logic              tick
);
    localparam logic [HPOS_W-1:0] TRIG_V = HPOS_W'(TRIG_COL);

    // Purpose: detect the scanline-start column.
    always_comb begin
        tick = (hpos == TRIG_V);
    end
endmodule

// File: rtl/tone_limit_sel.sv
// Module: tone_limit_sel
// Chooses the comparison limit from the displayed logic level.
// Assumes both limits fit in CNT_W bits.
module tone_limit_sel #(
    parameter int CNT_W    = 9,
    parameter int LIMIT_HI = 180,
    parameter int LIMIT_LO = 300
) (
    input  logic             level,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(LIMIT_HI);
    localparam logic [CNT_W-1:0] LO_V = CNT_W'(LIMIT_LO);

    // Purpose: map the level to its half-period limit.
    always_comb begin
        limit = level ? HI_V : LO_V;
    end
endmodule

// File: rtl/tone_half_counter.sv
// Module: tone_half_counter
// Counts step requests. When the count is strictly above the limit, it
// inverts the wave and restarts from zero. Assumes the limit is below the
// counter's maximum value.
module tone_half_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             wave
);
    logic wrap;

    // Purpose: decide whether this step ends a half period.
    always_comb begin
        wrap = (cnt > limit);
    end

    // Purpose: advance the counter and the wave once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (step) begin
            if (wrap) begin
                cnt  <= '0;
                wave <= ~wave;
            end else begin
                cnt  <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/line_tone_audio.sv
// Module: line_tone_audio (top)
// Dual-tone square-wave source stepped once per scanline from the video
// position. Assumes hpos_i comes from the video timing chain and level_i
// is synchronous to clk_i.
module line_tone_audio
    import line_tone_pkg::*;
#(
    parameter int P_HPOS_W   = HPOS_W,
    parameter int P_CNT_W    = CNT_W,
    parameter int P_LIMIT_HI = LIMIT_HI,
    parameter int P_LIMIT_LO = LIMIT_LO
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [P_HPOS_W-1:0] hpos_i,
    input  logic                level_i,
    output logic                audio_o
);
    logic               line_tick;
    logic [P_CNT_W-1:0] tone_limit;
    logic [P_CNT_W-1:0] tone_cnt;
    logic               tone_wave;

    tone_line_tick #(
        .HPOS_W  (P_HPOS_W),
        .TRIG_COL(0)
    ) u_tick (
        .hpos(hpos_i),
        .tick(line_tick)
    );

    tone_limit_sel #(
        .CNT_W   (P_CNT_W),
        .LIMIT_HI(P_LIMIT_HI),
        .LIMIT_LO(P_LIMIT_LO)
    ) u_limit (
        .level(level_i),
        .limit(tone_limit)
    );

    tone_half_counter #(
        .CNT_W(P_CNT_W)
    ) u_cnt (
        .clk  (clk_i),
        .rst_n(rst_ni),
        .step (line_tick),
        .limit(tone_limit),
        .cnt  (tone_cnt),
        .wave (tone_wave)
    );

    // Purpose: present the wave on the audio pin.
    always_comb begin
        audio_o = tone_wave;
    end
endmodule

// File: rtl/line_tone_audio_chk.sv
// Module: line_tone_audio_chk
// Temporal checks on the tone generator, bound into the top module.
// Assumes hpos is a defined value on every clock after reset.
module line_tone_audio_chk #(
    parameter int HPOS_W   = 10,
    parameter int CNT_W    = 9,
    parameter int LIMIT_HI = 180,
    parameter int LIMIT_LO = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HPOS_W-1:0] hpos,
    input logic              level,
    input logic              audio,
    input logic [CNT_W-1:0]  cnt
);
    localparam int MAX_LIM = (LIMIT_HI > LIMIT_LO) ? LIMIT_HI : LIMIT_LO;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] HI_V  = CNT_W'(LIMIT_HI);
    localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LIMIT_LO);

    // R1: reset drives the output low and clears the counter.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!audio && cnt == '0));

    // R2: no change away from the scanline-start column.
    p_hold_off_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hpos != '0) |=> ($stable(audio) && $stable(cnt)));

    // R3: a step with the count at or below the limit increments it.
    p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hpos == '0 && cnt <= (level ? HI_V : LO_V))
            |=> (cnt == $past(cnt) + CNT_W'(1) && $stable(audio)));

    // R3/R6: a step past the currently selected limit toggles and restarts.
    p_wrap_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hpos == '0 && cnt > (level ? HI_V : LO_V))
            |=> (cnt == '0 && audio != $past(audio)));

    // R7: the counter stays within the larger limit plus one.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP_V);
endmodule

bind line_tone_audio line_tone_audio_chk #(
    .HPOS_W  (P_HPOS_W),
    .CNT_W   (P_CNT_W),
    .LIMIT_HI(P_LIMIT_HI),
    .LIMIT_LO(P_LIMIT_LO)
) u_chk (
    .clk  (clk_i),
    .rst_n(rst_ni),
    .hpos (hpos_i),
    .level(level_i),
    .audio(audio_o),
    .cnt  (tone_cnt)
);

// File: tb/tb_line_tone_audio.sv
`timescale 1ns/100ps
// Bench for line_tone_audio: a vector table of level versus half-period
// length, followed by directed tests for reset, idle columns and level
// changes part-way through a half period.
module tb_line_tone_audio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] hpos = 10'd5;
    logic       level = 1'b1;
    logic       audio;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Each entry holds {level, expected line events until the next toggle}.
    localparam int NVEC = 7;
    localparam int VEC_LVL [NVEC] = '{1, 1, 0, 1, 0, 0, 1};
    localparam int VEC_EXP [NVEC] = '{182, 182, 302, 182, 302, 302, 182};

    line_tone_audio dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .hpos_i (hpos),
        .level_i(level),
        .audio_o(audio)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run is counted as a failure.
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One short scanline: position 0 for one cycle, then two other columns.
    task automatic do_line();
        @(negedge clk); hpos = 10'd0;
        @(negedge clk); hpos = 10'd1;
        @(negedge clk); hpos = 10'd2;
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) do_line();
    endtask

    // Counts line events until the audio output changes, up to a cap.
    task automatic lines_to_toggle(output int n);
        logic a0;
        a0 = audio;
        n = 0;
        while (n < 1000) begin
            do_line();
            n++;
            if (audio != a0) break;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); hpos = 10'd7;
        repeat (n) @(negedge clk);
    endtask

    int got;
    logic a_before;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 audio low in reset", int'(audio), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3/R4/R5: vector table walked from a freshly restarted counter
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk); level = VEC_LVL[v][0];
            lines_to_toggle(got);
            chk(VEC_LVL[v] != 0 ? "R4 half period high" : "R5 half period low",
                got, VEC_EXP[v]);
        end

        // R2: idle columns do not advance, at count 0 and mid-count
        level = 1'b1;
        a_before = audio;
        idle(2000);
        chk("R2 audio stable off line start", int'(audio), int'(a_before));
        lines_to_toggle(got);
        chk("R2 no advance at count 0", got, 182);
        run_lines(100);
        idle(2000);
        chk("R2 audio held mid-count", int'(audio), int'(a_before) ^ 1);
        lines_to_toggle(got);
        chk("R2 remaining after idle", got, 82);

        // R6: low -> high with the count at 200 toggles on the next event
        @(negedge clk); level = 1'b0;
        run_lines(200);
        @(negedge clk); level = 1'b1;
        lines_to_toggle(got);
        chk("R6 low to high past limit", got, 1);

        // R6: high -> low with the count at 100 needs 202 more events
        run_lines(100);
        @(negedge clk); level = 1'b0;
        lines_to_toggle(got);
        chk("R6 high to low keeps count", got, 202);

        // R7: longest half period is limit plus 2, never longer
        lines_to_toggle(got);
        chk("R7 low half period bound", got, 302);

        // R1: reset mid-count with the audio high
        if (audio == 1'b0) begin
            level = 1'b1;
            lines_to_toggle(got);
        end
        run_lines(50);
        chk("R1 audio high before reset", int'(audio), 1);
        @(negedge clk); rst_n = 1'b0; hpos = 10'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 audio cleared by reset", int'(audio), 0);
        rst_n = 1'b1; hpos = 10'd3; level = 1'b1;
        lines_to_toggle(got);
        chk("R1 counter cleared by reset", got, 182);
        chk("R3 toggle sets audio high", int'(audio), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule